// File: doc/BRIEF.md
# Command Response Timeout Monitor

This block guards the response phase of a memory-card host controller. When the command engine begins sending a command, an internal counter starts counting ticks of the card transfer clock. The counter is delivered as a one-cycle enable in the system clock domain. A completed response stops the counter and returns it to zero. So does a software abort of the command sequence. If neither comes in time, the counter reaches a limit picked by a 2-bit period select, and a timeout event fires.

The counter is not visible to software. It keeps running past the limit and wraps modulo 2^CNT_W, so the timeout event comes back every 2^CNT_W ticks until the command is aborted or answered. Because of this, software should abort first and only then clear the status flag. The event sets a sticky status flag only while the interrupt enable is on. The flag is write-1-to-clear. The interrupt output is high while the flag and the enable are both high.

Software reaches three 8-bit registers through a simple write strobe with a combinational read port:
- address 0: period select in bits 1:0; bits 7:2 read as 0 and ignore writes.
- address 1: interrupt enable in bit 0.
- address 2: status flag in bit 0.
- address 3: reads as 0.

Top module: `cmd_rsp_timeout`

## Requirements
- R1: After reset the period select, the enable and the flag are 0, every register reads 0 and irq_o is 0.
- R2: Address 0 stores wdata[1:0] as the period select and reads it back in bits 1:0; bits 7:2 always read 0.
- R3: With period select code 0, 1, 2 or 3, the limit is 128, 256, 512 or 1024 ticks. The flag sets on the tick that takes the count from limit-1 to limit, and not earlier.
- R4: The counter advances only on cycles where tclk_en_i is 1; idle cycles hold the count.
- R5: rsp_done_i clears the count to 0 and stops counting, so no timeout follows however many ticks come.
- R6: cmd_abort_i clears the count to 0 and stops counting, in the same way as rsp_done_i.
- R7: A timeout event sets the flag only while the enable (address 1, bit 0) is 1. Turning the enable on later does not set the flag.
- R8: The count runs on past the limit and wraps at 2048 ticks, so the event recurs 2048 ticks after the previous one.
- R9: Writing 1 to address 2 bit 0 clears the flag; writing 0 has no effect. A set in the same cycle as a clear wins.
- R10: irq_o is 1 exactly when the flag and the enable are both 1.
- R11: cmd_start_i while already counting restarts the count from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tclk_en_i | input | 1 | One-cycle pulse per transfer-clock tick |
| cmd_start_i | input | 1 | Strobe: command transmission begins |
| rsp_done_i | input | 1 | Strobe: response reception complete |
| cmd_abort_i | input | 1 | Strobe: software abort of the command sequence |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Timeout interrupt |

## Verification
A register write takes effect at the clock edge where it is sampled. Read data follows the address combinationally. The flag and irq_o change at the same edge as the tick that takes the count to the limit. The bench drives every input just after a falling edge and reads outputs just after the next falling edge, so each check sees the state left by exactly the rising edges it has counted. For the timeout boundaries, it counts ticks from the start strobe, checks the flag one tick short of the limit and checks again on the limit tick.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_IEN  = 2'd1,
    ADDR_STS  = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tmo_limit.sv
module tmo_limit #(
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 7,
  parameter int CNT_W     = BASE_LOG2 + (1 << SEL_W)
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] limit_o
);
  localparam int NUM_SEL = 1 << SEL_W;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] tbl [NUM_SEL];

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_tbl
    assign tbl[g] = ONE << (BASE_LOG2 + g);
  end

  assign limit_o = tbl[sel_i];
endmodule

// File: rtl/tmo_counter.sv
module tmo_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             done_i,
  input  logic             abort_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_o,
  output logic             evt_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic             stop;
  logic             adv;

  assign stop = done_i | abort_i;
  assign adv  = active_q & tick_i & ~stop & ~start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (stop) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (adv) begin
      cnt_q <= cnt_q + ONE;  // wraps; timeout recurs each 2^CNT_W ticks
    end
  end

  assign evt_o    = adv & ((cnt_q + ONE) == limit_i);
  assign cnt_o    = cnt_q;
  assign active_o = active_q;
endmodule

// File: rtl/tmo_regs.sv
module tmo_regs
  import tmo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              evt_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              ien_o,
  output logic              sts_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [SEL_W-1:0] sel_q;
  logic             ien_q;
  logic             sts_q;
  logic             wr_ctrl, wr_ien;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:SEL_W];

  assign wr_ctrl = we_i & (reg_addr_e'(addr_i) == ADDR_CTRL);
  assign wr_ien  = we_i & (reg_addr_e'(addr_i) == ADDR_IEN);
  assign clr_o   = we_i & (reg_addr_e'(addr_i) == ADDR_STS) & wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      ien_q <= 1'b0;
      sts_q <= 1'b0;
    end else begin
      if (wr_ctrl) sel_q <= wdata_i[SEL_W-1:0];
      if (wr_ien)  ien_q <= wdata_i[0];
      if (evt_i && ien_q) sts_q <= 1'b1;  // set beats clear
      else if (clr_o)     sts_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_addr_e'(addr_i))
      ADDR_CTRL: rdata_o[SEL_W-1:0] = sel_q;
      ADDR_IEN:  rdata_o[0] = ien_q;
      ADDR_STS:  rdata_o[0] = sts_q;
      default:   rdata_o = '0;
    endcase
  end

  assign sel_o = sel_q;
  assign ien_o = ien_q;
  assign sts_o = sts_q;
endmodule

// File: rtl/cmd_rsp_timeout.sv
module cmd_rsp_timeout #(
  parameter int DATA_W    = 8,
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 7,
  parameter int CNT_W     = BASE_LOG2 + (1 << SEL_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tclk_en_i,
  input  logic              cmd_start_i,
  input  logic              rsp_done_i,
  input  logic              cmd_abort_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt;
  logic             active;
  logic             evt;
  logic             ien;
  logic             sts;
  logic             clr;

  tmo_limit #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_limit (
    .sel_i   (sel),
    .limit_o (limit)
  );

  tmo_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tclk_en_i),
    .start_i  (cmd_start_i),
    .done_i   (rsp_done_i),
    .abort_i  (cmd_abort_i),
    .limit_i  (limit),
    .cnt_o    (cnt),
    .active_o (active),
    .evt_o    (evt)
  );

  tmo_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .evt_i   (evt),
    .sel_o   (sel),
    .ien_o   (ien),
    .sts_o   (sts),
    .clr_o   (clr),
    .rdata_o (reg_rdata_o)
  );

  assign irq_o = sts & ien;
endmodule

// File: rtl/tmo_chk.sv
module tmo_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              start_i,
  input logic              done_i,
  input logic              abort_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              active_i,
  input logic              ien_i,
  input logic              sts_i,
  input logic              clr_i,
  input logic              irq_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] rdata_i
);
  AST_STS_NEEDS_IEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_i) |-> $past(ien_i)); // R7
  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (cnt_i == '0) && !active_i); // R5
  AST_ABORT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (cnt_i == '0) && !active_i); // R6
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !start_i && !done_i && !abort_i) |=> $stable(cnt_i)); // R4
  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !done_i && !abort_i) |=> (cnt_i == '0) && active_i); // R11
  AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_i && !clr_i) |=> sts_i); // R9
  AST_IRQ_NEEDS_STS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_i |-> !irq_i); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd0) |-> (rdata_i[DATA_W-1:2] == '0)); // R2
endmodule

bind cmd_rsp_timeout tmo_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tclk_en_i),
  .start_i  (cmd_start_i),
  .done_i   (rsp_done_i),
  .abort_i  (cmd_abort_i),
  .cnt_i    (cnt),
  .active_i (active),
  .ien_i    (ien),
  .sts_i    (sts),
  .clr_i    (clr),
  .irq_i    (irq_o),
  .addr_i   (reg_addr_i),
  .rdata_i  (reg_rdata_o)
);

// File: tb/cmd_rsp_timeout_tb_top.sv
`timescale 1ns/1ps
module cmd_rsp_timeout_tb_top;
  localparam int PERIOD = 20;
  localparam int NVEC   = 8;
  // {sel[1:0], ticks[10:0], expected flag}
  localparam logic [13:0] VEC [NVEC] = '{
    {2'd0, 11'd127,  1'b0}, {2'd0, 11'd128,  1'b1},
    {2'd1, 11'd255,  1'b0}, {2'd1, 11'd256,  1'b1},
    {2'd2, 11'd511,  1'b0}, {2'd2, 11'd512,  1'b1},
    {2'd3, 11'd1023, 1'b0}, {2'd3, 11'd1024, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, start = 1'b0, done = 1'b0, abort = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;
  int         n_chk = 0, n_fail = 0;
  bit         finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  cmd_rsp_timeout dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tclk_en_i(tick), .cmd_start_i(start),
    .rsp_done_i(done), .cmd_abort_i(abort), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    {tick, start, done, abort, we} = '0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      {start, done, abort, we} = '0;
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    {tick, start, done, abort} = '0;
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse_start();
    {tick, done, abort, we} = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pulse_done();
    {tick, start, abort, we} = '0;
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic pulse_abort();
    {tick, start, done, we} = '0;
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
  endtask

  function automatic int rd(input logic [1:0] a);
    addr = a;
    return 0;
  endfunction

  task automatic read(input logic [1:0] a, output int v);
    int dummy;
    dummy = rd(a);
    #1 v = int'(rdata);
  endtask

  task automatic prep(input logic [1:0] sel, input logic ien);
    pulse_abort();
    wr(2'd2, 8'h01);
    wr(2'd0, {6'd0, sel});
    wr(2'd1, {7'd0, ien});
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      read(2'(a), v); check("R1 reg after reset", v, 0);
    end
    check("R1 irq after reset", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: R3 limit boundaries per period select
    for (int k = 0; k < NVEC; k++) begin
      prep(VEC[k][13:12], 1'b1);
      pulse_start();
      ticks(int'(VEC[k][11:1]));
      read(2'd2, v); check("R3 flag at tick count", v, int'(VEC[k][0]));
    end

    // R2 reserved bits
    wr(2'd0, 8'hFF);
    read(2'd0, v); check("R2 ctrl readback", v, 3);
    wr(2'd0, 8'hA6);
    read(2'd0, v); check("R2 ctrl readback", v, 2);

    // R4 idle cycles hold the count
    prep(2'd0, 1'b1);
    pulse_start();
    ticks(100);
    repeat (50) idle();
    ticks(27);
    read(2'd2, v); check("R4 held count, 127 ticks", v, 0);
    ticks(1);
    read(2'd2, v); check("R4 held count, 128 ticks", v, 1);

    // R5 response completes
    prep(2'd0, 1'b1);
    pulse_start();
    ticks(100);
    pulse_done();
    ticks(300);
    read(2'd2, v); check("R5 no timeout after response", v, 0);

    // R6 abort
    prep(2'd0, 1'b1);
    pulse_start();
    ticks(127);
    pulse_abort();
    ticks(300);
    read(2'd2, v); check("R6 no timeout after abort", v, 0);

    // R7 enable gates the flag
    prep(2'd0, 1'b0);
    pulse_start();
    ticks(130);
    read(2'd2, v); check("R7 flag with enable off", v, 0);
    check("R7 irq with enable off", int'(irq), 0);
    wr(2'd1, 8'h01);
    read(2'd2, v); check("R7 late enable does not set", v, 0);

    // R8 recurrence after wrap
    prep(2'd0, 1'b1);
    pulse_start();
    ticks(128);
    read(2'd2, v); check("R8 first hit", v, 1);
    wr(2'd2, 8'h01);
    read(2'd2, v); check("R9 W1C clears", v, 0);
    ticks(2047);
    read(2'd2, v); check("R8 before recurrence", v, 0);
    ticks(1);
    read(2'd2, v); check("R8 recurrence at 2048", v, 1);

    // R9 set wins over same-cycle clear; write 0 ignored
    prep(2'd0, 1'b1);
    pulse_start();
    ticks(127);
    {start, done, abort} = '0;
    tick = 1'b1; we = 1'b1; addr = 2'd2; wdata = 8'h01;
    @(negedge clk);
    tick = 1'b0; we = 1'b0;
    read(2'd2, v); check("R9 set beats clear", v, 1);
    wr(2'd2, 8'h00);
    read(2'd2, v); check("R9 write 0 no effect", v, 1);

    // R10 irq follows flag and enable
    check("R10 irq with flag and enable", int'(irq), 1);
    wr(2'd1, 8'h00);
    #1 check("R10 irq enable off", int'(irq), 0);
    read(2'd2, v); check("R10 flag kept", v, 1);
    wr(2'd1, 8'h01);
    #1 check("R10 irq re-enabled", int'(irq), 1);
    wr(2'd2, 8'h01);
    #1 check("R10 irq after clear", int'(irq), 0);

    // R11 restart while counting
    prep(2'd0, 1'b1);
    pulse_start();
    ticks(100);
    pulse_start();
    ticks(100);
    read(2'd2, v); check("R11 restarted, 100 ticks", v, 0);
    ticks(27);
    read(2'd2, v); check("R11 restarted, 127 ticks", v, 0);
    ticks(1);
    read(2'd2, v); check("R11 restarted, 128 ticks", v, 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule